// File: doc/BRIEF.md
# Shift Coprocessor Control Unit

This unit sequences a small data-transfer coprocessor on behalf of a host core. The host writes a three-bit control word (run, pointer-init, program-load) and a pointer register, and reads back a status view made of a two-bit state code, a rejected-write flag and an illegal-command flag. A byte-wide program memory can be filled by the host only while the unit sits in its load state. The execution pointer only changes to a new start address when the unit passes through a separate pointer-change state.

The unit has four states. **Idle** is the resting state. **RamLoad** opens the program memory to host writes. **PointerChange** commits the host pointer register into the execution pointer. **Running** lets the coprocessor advance. The named transitions are these. *IdleToLoad*: only the load bit is set while in Idle. *IdleToPtr*: only the init bit is set. *IdleToRun*: only the run bit is set. *LoadToIdle*: the load bit is cleared. *PtrToIdle*: the init bit is cleared. *RunToIdle*: the run bit is cleared. *IdleHold*: no bit is set, or more than one bit is set.

A stub engine stands in for the real instruction decoder. It advances the pointer once per cycle while Running. On odd pointer values it claims a shared data buffer. The host uses the same buffer through a request/grant port. When both ask in the same cycle, the coprocessor wins and the host is held off for that one cycle.

Top module: `xfer_cop_ctrl`

## Requirements
- R1: After reset the state code is 00 (Idle), the execution pointer is 0, both flags are 0, the control word is 0 and every buffer byte reads 0.
- R2: `state_o` encodes the state as 00 Idle, 01 RamLoad, 10 Running, 11 PointerChange. A control write reaches `state_o` after the second rising edge that follows it.
- R3: In Idle with only control bit 2 (load) set, the unit enters RamLoad. A program write there is stored and can be read back on `pram_rdata`. Clearing bit 2 returns the unit to Idle.
- R4: A program write made in any state other than RamLoad leaves the memory unchanged and sets `wr_reject_o` one edge later. An accepted write clears the flag.
- R5: In Idle with only control bit 1 (init) set, the unit enters PointerChange. On the same edge the pointer register is copied into the execution pointer. Clearing bit 1 returns the unit to Idle.
- R6: In Idle with only control bit 0 (run) set, the unit enters Running with the execution pointer at the committed value. The pointer then rises by one per cycle and wraps from 255 to 0.
- R7: Clearing bit 0 while Running returns the unit to Idle. The pointer takes one last step on that edge and then holds.
- R8: In Idle with two or more control bits set, the unit stays in Idle. `illegal_o` is 1 after each such edge and returns to 0 after an edge without that condition.
- R9: While Running with an odd pointer, `cop_req_o` is 1. On that edge the buffer byte at address (pointer mod 16) is written with the pointer value.
- R10: `host_gnt` equals host request AND NOT `cop_req_o` in the same cycle. A granted host write lands on the edge. `host_rdata` shows the addressed buffer byte combinationally. A held-off request is never held off two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: bit0 run, bit1 init, bit2 load |
| ptr_we | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 8 | Pointer register value |
| pram_we | input | 1 | Program memory write strobe |
| pram_addr | input | 8 | Program memory write address |
| pram_wdata | input | 8 | Program memory write byte |
| pram_raddr | input | 8 | Program memory read address |
| pram_rdata | output | 8 | Program memory read byte |
| host_req | input | 1 | Host buffer access request |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | 4 | Host buffer address |
| host_wdata | input | 8 | Host buffer write byte |
| host_rdata | output | 8 | Host buffer read byte |
| host_gnt | output | 1 | Host access granted this cycle |
| state_o | output | 2 | State code |
| wr_reject_o | output | 1 | Last program write was rejected |
| illegal_o | output | 1 | Illegal control combination seen in Idle |
| exec_ptr_o | output | 8 | Execution pointer |
| cop_req_o | output | 1 | Coprocessor buffer claim |

## Verification
A control write is registered on the first rising edge and shows on `state_o` after the second. The pointer commit shows in the same cycle as the PointerChange code. The flags follow the edge that sees their cause. Grant and read data are combinational with the current inputs and state. The bench drives inputs at the falling edge and checks the combinational outputs shortly after. It then updates its own state model at the rising edge and compares every registered output at the next falling edge, so each result is sampled in the cycle it is due.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOAD = 2'b01,
        ST_RUN  = 2'b10,
        ST_PCHG = 2'b11
    } cop_state_e;

    localparam int CTL_W    = 3;
    localparam int CTL_RUN  = 0;
    localparam int CTL_INIT = 1;
    localparam int CTL_LOAD = 2;
endpackage

// File: rtl/cop_fsm.sv
module cop_fsm
    import cop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output cop_state_e       state_o,
    output logic             enter_pchg_o,
    output logic             illegal_o
);
    logic [CTL_W-1:0] ctl_q;
    cop_state_e       state_q, state_d;
    logic             multi;

    assign multi = (32'($countones(ctl_q)) > 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (multi)                state_d = ST_IDLE;
                else if (ctl_q[CTL_LOAD]) state_d = ST_LOAD;
                else if (ctl_q[CTL_INIT]) state_d = ST_PCHG;
                else if (ctl_q[CTL_RUN])  state_d = ST_RUN;
            end
            ST_LOAD: if (!ctl_q[CTL_LOAD]) state_d = ST_IDLE;
            ST_PCHG: if (!ctl_q[CTL_INIT]) state_d = ST_IDLE;
            ST_RUN:  if (!ctl_q[CTL_RUN])  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) illegal_o <= 1'b0;
        else        illegal_o <= (state_q == ST_IDLE) && multi;
    end

    assign state_o      = state_q;
    assign enter_pchg_o = (state_q == ST_IDLE) && (state_d == ST_PCHG);

    a_r3_enter_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctl_q == 3'b100) |=> (state_q == ST_LOAD));
    a_r5_enter_pchg: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctl_q == 3'b010) |=> (state_q == ST_PCHG));
    a_r7_run_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !ctl_q[CTL_RUN]) |=> (state_q == ST_IDLE));
    a_r8_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $countones(ctl_q) > 1) |=> (state_q == ST_IDLE && illegal_o));
endmodule

// File: rtl/cop_engine.sv
module cop_engine #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             commit,
    input  logic             is_run,
    output logic [PTR_W-1:0] exec_ptr_o,
    output logic             cop_req_o
);
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else if (ptr_we) ptr_q <= ptr_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      exec_ptr_o <= '0;
        else if (commit) exec_ptr_o <= ptr_q;
        else if (is_run) exec_ptr_o <= exec_ptr_o + 1'b1;
    end

    assign cop_req_o = is_run && exec_ptr_o[0];

    a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (exec_ptr_o == $past(ptr_q)));
    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        is_run |=> (exec_ptr_o == $past(exec_ptr_o) + 1'b1));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_run && !commit) |=> $stable(exec_ptr_o));
endmodule

// File: rtl/cop_prog_ram.sv
module cop_prog_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          reject_o
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && load_en) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  reject_o <= 1'b0;
        else if (we) reject_o <= !load_en;
    end

    assign rdata = mem[raddr];

    a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !load_en) |=> reject_o);
    a_r4_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we && load_en) |=> !reject_o);
endmodule

// File: rtl/cop_buf_arb.sv
module cop_buf_arb #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_gnt,
    input  logic          cop_req,
    input  logic [AW-1:0] cop_addr,
    input  logic [DW-1:0] cop_wdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] buf_q [DEPTH];

    assign host_gnt   = host_req && !cop_req;
    assign host_rdata = buf_q[host_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
        end else if (cop_req) begin
            buf_q[cop_addr] <= cop_wdata;
        end else if (host_gnt && host_we) begin
            buf_q[host_addr] <= host_wdata;
        end
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_gnt && cop_req));
    a_r10_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && cop_req) |=> !cop_req);
endmodule

// File: rtl/xfer_cop_ctrl.sv
module xfer_cop_ctrl
    import cop_pkg::*;
#(
    parameter int PROG_BYTES = 256,
    parameter int DATA_W     = 8,
    parameter int BUF_DEPTH  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [2:0]  ctl_wdata,
    input  logic        ptr_we,
    input  logic [$clog2(PROG_BYTES)-1:0] ptr_wdata,
    input  logic        pram_we,
    input  logic [$clog2(PROG_BYTES)-1:0] pram_addr,
    input  logic [DATA_W-1:0] pram_wdata,
    input  logic [$clog2(PROG_BYTES)-1:0] pram_raddr,
    output logic [DATA_W-1:0] pram_rdata,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [$clog2(BUF_DEPTH)-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic        host_gnt,
    output logic [1:0]  state_o,
    output logic        wr_reject_o,
    output logic        illegal_o,
    output logic [$clog2(PROG_BYTES)-1:0] exec_ptr_o,
    output logic        cop_req_o
);
    localparam int PROG_AW = $clog2(PROG_BYTES);
    localparam int BUF_AW  = $clog2(BUF_DEPTH);

    cop_state_e state;
    logic       commit;

    cop_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .state_o(state), .enter_pchg_o(commit), .illegal_o(illegal_o)
    );

    cop_engine #(.PTR_W(PROG_AW)) u_eng (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .commit(commit), .is_run(state == ST_RUN),
        .exec_ptr_o(exec_ptr_o), .cop_req_o(cop_req_o)
    );

    cop_prog_ram #(.AW(PROG_AW), .DW(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .load_en(state == ST_LOAD),
        .we(pram_we), .waddr(pram_addr), .wdata(pram_wdata),
        .raddr(pram_raddr), .rdata(pram_rdata), .reject_o(wr_reject_o)
    );

    cop_buf_arb #(.AW(BUF_AW), .DW(DATA_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_gnt(host_gnt),
        .cop_req(cop_req_o), .cop_addr(exec_ptr_o[BUF_AW-1:0]),
        .cop_wdata(DATA_W'(exec_ptr_o))
    );

    assign state_o = state;

    a_r9_req_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        cop_req_o |-> (state_o == 2'b10));
endmodule

// File: tb/xfer_cop_ctrl_tb.sv
module xfer_cop_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 0;
    logic [2:0] ctl_wdata = 0;
    logic       ptr_we = 0;
    logic [7:0] ptr_wdata = 0;
    logic       pram_we = 0;
    logic [7:0] pram_addr = 0, pram_wdata = 0, pram_raddr = 0;
    logic [7:0] pram_rdata;
    logic       host_req = 0, host_we = 0;
    logic [3:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       host_gnt;
    logic [1:0] state_o;
    logic       wr_reject_o, illegal_o, cop_req_o;
    logic [7:0] exec_ptr_o;

    always #5 clk = ~clk;

    xfer_cop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .pram_we(pram_we),
        .pram_addr(pram_addr), .pram_wdata(pram_wdata), .pram_raddr(pram_raddr),
        .pram_rdata(pram_rdata), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_gnt(host_gnt), .state_o(state_o), .wr_reject_o(wr_reject_o),
        .illegal_o(illegal_o), .exec_ptr_o(exec_ptr_o), .cop_req_o(cop_req_o)
    );

    int n_cmp = 0, n_err = 0;
    bit done = 0;

    // reference model
    logic [2:0] m_ctl;
    logic [1:0] m_st;
    logic       m_ill, m_rej;
    logic [7:0] m_preg, m_exec;
    logic [7:0] m_buf [16];
    logic [7:0] m_mem [256];
    bit         m_val [256];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ones3(input logic [2:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]);
    endfunction

    function automatic logic [1:0] next_state(input logic [1:0] st, input logic [2:0] c);
        case (st)
            2'b00: begin
                if (ones3(c) > 1) return 2'b00;
                if (c[2]) return 2'b01;
                if (c[1]) return 2'b11;
                if (c[0]) return 2'b10;
                return 2'b00;
            end
            2'b01:   return c[2] ? 2'b01 : 2'b00;
            2'b11:   return c[1] ? 2'b11 : 2'b00;
            default: return c[0] ? 2'b10 : 2'b00;
        endcase
    endfunction

    function automatic logic m_copreq();
        return (m_st == 2'b10) && m_exec[0];
    endfunction

    task automatic model_reset();
        m_ctl = 0; m_st = 0; m_ill = 0; m_rej = 0; m_preg = 0; m_exec = 0;
        for (int i = 0; i < 16; i++) m_buf[i] = 0;
        for (int i = 0; i < 256; i++) m_val[i] = 0;
    endtask

    task automatic check_regs();
        chk("R2 state", 32'(state_o), 32'(m_st));
        chk("R6 exec_ptr", 32'(exec_ptr_o), 32'(m_exec));
        chk("R8 illegal", 32'(illegal_o), 32'(m_ill));
        chk("R4 reject", 32'(wr_reject_o), 32'(m_rej));
    endtask

    // one clock: comb checks, edge, model update, registered checks
    task automatic cycle();
        logic [1:0] st_n;
        logic       cr;
        #1;
        cr = m_copreq();
        chk("R9 cop_req", 32'(cop_req_o), 32'(cr));
        chk("R10 grant", 32'(host_gnt), 32'(host_req && !cr));
        chk("R10 rdata", 32'(host_rdata), 32'(m_buf[host_addr]));
        if (m_val[pram_raddr]) chk("R3 pram read", 32'(pram_rdata), 32'(m_mem[pram_raddr]));
        @(posedge clk);
        st_n = next_state(m_st, m_ctl);
        m_ill = (m_st == 2'b00) && (ones3(m_ctl) > 1);
        if (pram_we) begin
            if (m_st == 2'b01) begin
                m_mem[pram_addr] = pram_wdata; m_val[pram_addr] = 1; m_rej = 0;
            end else m_rej = 1;
        end
        if (cr) m_buf[m_exec[3:0]] = m_exec;
        else if (host_req && host_we) m_buf[host_addr] = host_wdata;
        if (m_st == 2'b00 && st_n == 2'b11) m_exec = m_preg;
        else if (m_st == 2'b10) m_exec = m_exec + 8'd1;
        if (ptr_we) m_preg = ptr_wdata;
        if (ctl_we) m_ctl = ctl_wdata;
        m_st = st_n;
        @(negedge clk);
        check_regs();
    endtask

    task automatic idle_in();
        ctl_we = 0; ptr_we = 0; pram_we = 0; host_req = 0; host_we = 0;
    endtask

    task automatic wr_ctl(input logic [2:0] v);
        ctl_we = 1; ctl_wdata = v; cycle(); ctl_we = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 state", 32'(state_o), 32'd0);
        chk("R1 exec_ptr", 32'(exec_ptr_o), 32'd0);
        chk("R1 flags", 32'({illegal_o, wr_reject_o}), 32'd0);
        host_addr = 4'd7; #1;
        chk("R1 buffer", 32'(host_rdata), 32'd0);

        // R4 write in Idle rejected
        pram_we = 1; pram_addr = 8'h10; pram_wdata = 8'hAA; cycle(); pram_we = 0;
        chk("R4 reject in idle", 32'(wr_reject_o), 32'd1);

        // R3 load program
        wr_ctl(3'b100); cycle();
        chk("R3 in RamLoad", 32'(state_o), 32'b01);
        for (int i = 0; i < 8; i++) begin
            pram_we = 1; pram_addr = 8'(i); pram_wdata = 8'(8'h30 + i); cycle();
        end
        pram_we = 0;
        chk("R4 accept clears", 32'(wr_reject_o), 32'd0);
        wr_ctl(3'b000); cycle();
        chk("R3 back to Idle", 32'(state_o), 32'b00);
        pram_we = 1; pram_addr = 8'h02; pram_wdata = 8'hEE; cycle(); pram_we = 0;
        pram_raddr = 8'h02; cycle();
        chk("R4 protected byte", 32'(pram_rdata), 32'h32);

        // R5 commit pointer
        ptr_we = 1; ptr_wdata = 8'hFC; cycle(); ptr_we = 0;
        wr_ctl(3'b010); cycle();
        chk("R5 PointerChange", 32'(state_o), 32'b11);
        chk("R5 committed", 32'(exec_ptr_o), 32'hFC);
        wr_ctl(3'b000); cycle();

        // R6 run with wrap, R10 contention
        wr_ctl(3'b001); cycle();
        chk("R6 start ptr", 32'(exec_ptr_o), 32'hFC);
        host_req = 1; host_we = 1; host_addr = 4'd3; host_wdata = 8'h5A;
        repeat (6) cycle();
        idle_in();
        chk("R6 wrapped", 32'(exec_ptr_o), 32'h02);
        // R7 stop
        wr_ctl(3'b000); cycle();
        chk("R7 Idle", 32'(state_o), 32'b00);
        cycle();
        chk("R7 pointer holds", 32'(exec_ptr_o), 32'(m_exec));

        // R8 illegal combination
        wr_ctl(3'b111); cycle();
        chk("R8 stays Idle", 32'(state_o), 32'b00);
        chk("R8 flag", 32'(illegal_o), 32'd1);
        wr_ctl(3'b000); cycle();
        chk("R8 flag clears", 32'(illegal_o), 32'd0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] r;
            r = 3'($urandom % 8);
            ctl_we = ($urandom % 10) == 0;
            case (r)
                3'd0, 3'd1, 3'd2: ctl_wdata = 3'b000;
                3'd3: ctl_wdata = 3'b001;
                3'd4: ctl_wdata = 3'b010;
                3'd5: ctl_wdata = 3'b100;
                default: ctl_wdata = 3'($urandom);
            endcase
            ptr_we = ($urandom % 8) == 0; ptr_wdata = 8'($urandom);
            pram_we = ($urandom % 3) == 0; pram_addr = 8'($urandom % 32);
            pram_wdata = 8'($urandom); pram_raddr = 8'($urandom % 32);
            host_req = $urandom % 2; host_we = $urandom % 2;
            host_addr = 4'($urandom); host_wdata = 8'($urandom);
            cycle();
        end
        idle_in();
        cycle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule